// File: doc/BRIEF.md
# External Interrupt Edge Detector

This block turns eight asynchronous external request pins into interrupt request pulses that last one clock cycle. Each channel has two configuration bits. One bit sits in a rising-sensitivity register and the other in a falling-sensitivity register. Together the pair selects one of four modes for the channel: ignore the pin, react to falling transitions, react to rising transitions, or react to both.

Every pin passes through a two-stage synchronizer. A history flop then follows the synchronized level on every cycle, whatever the configuration. A transition is the synchronized level differing from its history copy. If the channel's current mode accepts that transition, the block drives a registered request pulse.

Software reaches the two registers over a plain byte bus. A write can replace a whole byte, or it can set or clear a single bit chosen by a 3-bit index. Reads return the register contents, have no side effects, and return zero for any other address.

Top module: `exti_edge_unit`

## Requirements
- R1: While reset is asserted, both sensitivity registers hold 00H and no request output is high.
- R2: A byte write to address FF48H replaces the rising-sensitivity register, and one to FF49H replaces the falling-sensitivity register. A read with the bus address at either location returns that register's value in the same cycle.
- R3: A bit operation (`bus_bitop_i` high with `bus_wr_i`) writes `bus_bitval_i` into bit `bus_bitidx_i` of the addressed register. All other bits of both registers are unchanged.
- R4: A write of either kind to any address other than FF48H or FF49H leaves both registers unchanged. A read from such an address returns 00H.
- R5: A channel whose rising and falling bits are both 0 never raises its request, whatever its pin does.
- R6: A channel with falling bit 1 and rising bit 0 pulses on every 1-to-0 pin transition and on no 0-to-1 transition.
- R7: A channel with rising bit 1 and falling bit 0 pulses on every 0-to-1 pin transition and on no 1-to-0 transition.
- R8: A channel with both bits at 1 gives one pulse for each transition in either direction.
- R9: A pin change first sampled at clock edge k raises the request after edge k+2, for exactly one cycle. Bit n of each register controls channel n only.
- R10: A level change made while a channel is disabled does not produce a pulse when the channel is enabled later.
- R11: When a register write and a detected transition fall in the same cycle, the transition is judged against the register value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| pin_i | input | 8 | Asynchronous external request pins |
| bus_addr_i | input | 16 | Register address for reads and writes |
| bus_wr_i | input | 1 | Write strobe |
| bus_bitop_i | input | 1 | 1: single-bit operation, 0: whole-byte write |
| bus_bitidx_i | input | 3 | Bit index for a single-bit operation |
| bus_bitval_i | input | 1 | Value written by a bit operation (1 set, 0 clear) |
| bus_wdata_i | input | 8 | Byte write data |
| bus_rdata_o | output | 8 | Read data for the current address |
| irq_o | output | 8 | Per-channel one-cycle request pulses |

## Verification
A configuration write can land in the same cycle that the edge logic sees a transition on the channel being reconfigured. The bench provokes this by toggling a pin and then placing the write exactly two cycles later, in the cycle in which the synchronized level and its history differ. It does this twice: once to disable a channel that was armed, and once to arm a channel that was disabled. In both cases the pulse must follow the old register value, so the disable case still fires and the arm case stays silent.

// File: rtl/exti_pkg.sv
package exti_pkg;

    // Mode of one channel, formed as {rising bit, falling bit}
    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_FALL = 2'b01,
        MODE_RISE = 2'b10,
        MODE_BOTH = 2'b11
    } edge_mode_e;

    function automatic logic mode_accepts(edge_mode_e mode, logic went_up, logic went_down);
        logic hit;
        unique case (mode)
            MODE_OFF:  hit = 1'b0;
            MODE_FALL: hit = went_down;
            MODE_RISE: hit = went_up;
            MODE_BOTH: hit = went_up | went_down;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/exti_sync.sv
module exti_sync #(
    parameter int unsigned NUM_CH = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_CH-1:0] pin_i,
    output logic [NUM_CH-1:0] lvl_o,
    output logic [NUM_CH-1:0] prev_o
);

    typedef struct packed {
        logic [NUM_CH-1:0] meta;
        logic [NUM_CH-1:0] lvl;
        logic [NUM_CH-1:0] prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = pin_i;
        st_d.lvl  = st_q.meta;
        // history follows the level even for disabled channels
        st_d.prev = st_q.lvl;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o  = st_q.lvl;
    assign prev_o = st_q.prev;

endmodule

// File: rtl/exti_cfg_regs.sv
module exti_cfg_regs #(
    parameter int unsigned NUM_CH    = 8,
    parameter int unsigned AW        = 16,
    parameter logic [AW-1:0] RISE_ADDR = 16'hFF48,
    parameter logic [AW-1:0] FALL_ADDR = 16'hFF49,
    localparam int unsigned IW       = $clog2(NUM_CH)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [AW-1:0]     bus_addr_i,
    input  logic              bus_wr_i,
    input  logic              bus_bitop_i,
    input  logic [IW-1:0]     bus_bitidx_i,
    input  logic              bus_bitval_i,
    input  logic [NUM_CH-1:0] bus_wdata_i,
    output logic [NUM_CH-1:0] bus_rdata_o,
    output logic [NUM_CH-1:0] rise_en_o,
    output logic [NUM_CH-1:0] fall_en_o
);

    typedef struct packed {
        logic [NUM_CH-1:0] rise;
        logic [NUM_CH-1:0] fall;
    } cfg_st_t;

    cfg_st_t cfg_d, cfg_q;
    logic    hit_rise, hit_fall;

    assign hit_rise = (bus_addr_i == RISE_ADDR);
    assign hit_fall = (bus_addr_i == FALL_ADDR);

    always_comb begin
        cfg_d = cfg_q;
        if (bus_wr_i) begin
            if (bus_bitop_i) begin
                if (hit_rise) cfg_d.rise[bus_bitidx_i] = bus_bitval_i;
                if (hit_fall) cfg_d.fall[bus_bitidx_i] = bus_bitval_i;
            end else begin
                if (hit_rise) cfg_d.rise = bus_wdata_i;
                if (hit_fall) cfg_d.fall = bus_wdata_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        if (hit_rise)      bus_rdata_o = cfg_q.rise;
        else if (hit_fall) bus_rdata_o = cfg_q.fall;
        else               bus_rdata_o = '0;
    end

    assign rise_en_o = cfg_q.rise;
    assign fall_en_o = cfg_q.fall;

    // R1
    reset_clears_chk: assert property (@(posedge clk_i)
        !rst_ni |=> (rise_en_o == '0) && (fall_en_o == '0));

    // R3
    single_bit_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && bus_bitop_i) |=>
            ($countones({rise_en_o, fall_en_o} ^ $past({rise_en_o, fall_en_o})) <= 1));

    // R4
    stray_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && !hit_rise && !hit_fall) |=> ($stable(rise_en_o) && $stable(fall_en_o)));

endmodule

// File: rtl/exti_edge_detect.sv
module exti_edge_detect
    import exti_pkg::*;
#(
    parameter int unsigned NUM_CH = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_CH-1:0] lvl_i,
    input  logic [NUM_CH-1:0] prev_i,
    input  logic [NUM_CH-1:0] rise_en_i,
    input  logic [NUM_CH-1:0] fall_en_i,
    output logic [NUM_CH-1:0] irq_o
);

    typedef struct packed {
        logic [NUM_CH-1:0] irq;
    } det_st_t;

    det_st_t det_d, det_q;

    always_comb begin
        det_d = det_q;
        for (int unsigned ch = 0; ch < NUM_CH; ch++) begin
            det_d.irq[ch] = mode_accepts(edge_mode_e'({rise_en_i[ch], fall_en_i[ch]}),
                                         lvl_i[ch] & ~prev_i[ch],
                                         ~lvl_i[ch] & prev_i[ch]);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            det_q <= '0;
        end else begin
            det_q <= det_d;
        end
    end

    assign irq_o = det_q.irq;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R5
        off_channel_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            irq_o[g] |-> $past(rise_en_i[g] | fall_en_i[g]));
        // R7
        rise_only_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (irq_o[g] && !$past(fall_en_i[g])) |-> $past(lvl_i[g]));
        // R6
        fall_only_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (irq_o[g] && !$past(rise_en_i[g])) |-> !$past(lvl_i[g]));
    end

endmodule

// File: rtl/exti_edge_unit.sv
module exti_edge_unit #(
    parameter int unsigned NUM_CH    = 8,
    parameter int unsigned AW        = 16,
    parameter logic [AW-1:0] RISE_ADDR = 16'hFF48,
    parameter logic [AW-1:0] FALL_ADDR = 16'hFF49,
    localparam int unsigned IW       = $clog2(NUM_CH)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_CH-1:0] pin_i,
    input  logic [AW-1:0]     bus_addr_i,
    input  logic              bus_wr_i,
    input  logic              bus_bitop_i,
    input  logic [IW-1:0]     bus_bitidx_i,
    input  logic              bus_bitval_i,
    input  logic [NUM_CH-1:0] bus_wdata_i,
    output logic [NUM_CH-1:0] bus_rdata_o,
    output logic [NUM_CH-1:0] irq_o
);

    logic [NUM_CH-1:0] lvl, prev, rise_en, fall_en;

    exti_sync #(.NUM_CH(NUM_CH)) sync_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (pin_i),
        .lvl_o  (lvl),
        .prev_o (prev)
    );

    exti_cfg_regs #(
        .NUM_CH   (NUM_CH),
        .AW       (AW),
        .RISE_ADDR(RISE_ADDR),
        .FALL_ADDR(FALL_ADDR)
    ) regs_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .bus_addr_i   (bus_addr_i),
        .bus_wr_i     (bus_wr_i),
        .bus_bitop_i  (bus_bitop_i),
        .bus_bitidx_i (bus_bitidx_i),
        .bus_bitval_i (bus_bitval_i),
        .bus_wdata_i  (bus_wdata_i),
        .bus_rdata_o  (bus_rdata_o),
        .rise_en_o    (rise_en),
        .fall_en_o    (fall_en)
    );

    exti_edge_detect #(.NUM_CH(NUM_CH)) det_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .lvl_i     (lvl),
        .prev_i    (prev),
        .rise_en_i (rise_en),
        .fall_en_i (fall_en),
        .irq_o     (irq_o)
    );

    // R1
    irq_quiet_in_reset_chk: assert property (@(posedge clk_i)
        !rst_ni |=> (irq_o == '0));

endmodule

// File: tb/exti_edge_unit_tb.sv
module exti_edge_unit_tb_top;

    localparam logic [15:0] A_RISE = 16'hFF48;
    localparam logic [15:0] A_FALL = 16'hFF49;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [7:0]  pin_i = '0;
    logic [15:0] bus_addr_i = '0;
    logic        bus_wr_i = 1'b0;
    logic        bus_bitop_i = 1'b0;
    logic [2:0]  bus_bitidx_i = '0;
    logic        bus_bitval_i = 1'b0;
    logic [7:0]  bus_wdata_i = '0;
    logic [7:0]  bus_rdata_o;
    logic [7:0]  irq_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] m_rise = '0;
    logic [7:0] m_fall = '0;

    always #4 clk_i = ~clk_i;

    exti_edge_unit dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i),
        .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i), .bus_bitop_i(bus_bitop_i),
        .bus_bitidx_i(bus_bitidx_i), .bus_bitval_i(bus_bitval_i),
        .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_fire(int ch, logic newlvl);
        logic [7:0] v = '0;
        v[ch] = newlvl ? m_rise[ch] : m_fall[ch];
        return v;
    endfunction

    function automatic logic [7:0] model_read(logic [15:0] a);
        if (a == A_RISE) return m_rise;
        if (a == A_FALL) return m_fall;
        return 8'h00;
    endfunction

    task automatic wr_byte(logic [15:0] a, logic [7:0] d);
        bus_addr_i = a; bus_wdata_i = d; bus_bitop_i = 1'b0; bus_wr_i = 1'b1;
        @(negedge clk_i);
        bus_wr_i = 1'b0;
        if (a == A_RISE) m_rise = d;
        if (a == A_FALL) m_fall = d;
    endtask

    task automatic wr_bit(logic [15:0] a, int idx, logic val);
        bus_addr_i = a; bus_bitidx_i = 3'(idx); bus_bitval_i = val;
        bus_bitop_i = 1'b1; bus_wr_i = 1'b1;
        @(negedge clk_i);
        bus_wr_i = 1'b0; bus_bitop_i = 1'b0;
        if (a == A_RISE) m_rise[idx] = val;
        if (a == A_FALL) m_fall[idx] = val;
    endtask

    task automatic rd_check(logic [15:0] a, string req);
        bus_addr_i = a;
        #1;
        check(req, bus_rdata_o, model_read(a));
    endtask

    // Toggle one pin at a negedge and watch the four following negedges.
    task automatic toggle_check(int ch, string req);
        logic [7:0] e;
        pin_i[ch] = ~pin_i[ch];
        e = exp_fire(ch, pin_i[ch]);
        @(negedge clk_i); check({req, " R9 early"}, irq_o, 8'h00);
        @(negedge clk_i); check({req, " R9 early"}, irq_o, 8'h00);
        @(negedge clk_i); check(req, irq_o, e);
        @(negedge clk_i); check({req, " R9 width"}, irq_o, 8'h00);
    endtask

    // Toggle a pin, then write the rising register in the detection cycle.
    task automatic collide(int ch, logic [7:0] newrise, string req);
        logic [7:0] e;
        pin_i[ch] = ~pin_i[ch];
        e = exp_fire(ch, pin_i[ch]);
        @(negedge clk_i);
        @(negedge clk_i);
        bus_addr_i = A_RISE; bus_wdata_i = newrise; bus_bitop_i = 1'b0; bus_wr_i = 1'b1;
        @(negedge clk_i);
        bus_wr_i = 1'b0;
        m_rise = newrise;
        check(req, irq_o, e);
        @(negedge clk_i); check(req, irq_o, 8'h00);
    endtask

    initial begin : watchdog
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5EED_0101));
        repeat (4) @(negedge clk_i);
        // R1 reset state
        check("R1 irq", irq_o, 8'h00);
        rd_check(A_RISE, "R1 rise reg");
        rd_check(A_FALL, "R1 fall reg");
        rst_ni = 1'b1;
        @(negedge clk_i);

        // R2 byte writes and readback
        wr_byte(A_RISE, 8'hA5); rd_check(A_RISE, "R2 rise");
        wr_byte(A_FALL, 8'h3C); rd_check(A_FALL, "R2 fall");

        // R3 bit operations
        wr_bit(A_RISE, 7, 1'b0); rd_check(A_RISE, "R3 clear"); rd_check(A_FALL, "R3 other reg");
        wr_bit(A_FALL, 0, 1'b1); rd_check(A_FALL, "R3 set");   rd_check(A_RISE, "R3 other reg");

        // R4 stray address
        wr_byte(16'hFF4A, 8'hFF); wr_bit(16'hFF47, 2, 1'b1);
        rd_check(A_RISE, "R4 rise kept"); rd_check(A_FALL, "R4 fall kept");
        rd_check(16'hFF4A, "R4 read zero");

        // Mode per channel: 0 off, 1 fall, 2 rise, 3 both
        wr_byte(A_RISE, 8'b0000_1100);
        wr_byte(A_FALL, 8'b0000_1010);
        for (int k = 0; k < 2; k++) begin
            toggle_check(0, "R5 off");
            toggle_check(1, "R6 fall-only");
            toggle_check(2, "R7 rise-only");
            toggle_check(3, "R8 both");
        end

        // R10 history tracks while disabled
        wr_byte(A_RISE, 8'h00); wr_byte(A_FALL, 8'h00);
        pin_i[5] = ~pin_i[5];
        repeat (6) begin @(negedge clk_i); check("R10 disabled", irq_o, 8'h00); end
        wr_byte(A_RISE, 8'hFF); wr_byte(A_FALL, 8'hFF);
        repeat (6) begin @(negedge clk_i); check("R10 enable no stale", irq_o, 8'h00); end

        // R11 collision: disable during detection still fires; arm stays silent
        wr_byte(A_FALL, 8'h00);
        wr_byte(A_RISE, 8'h10);
        if (pin_i[4]) toggle_check(4, "R7 prep");
        collide(4, 8'h00, "R11 disable");
        if (pin_i[4]) toggle_check(4, "R5 prep");
        collide(4, 8'h10, "R11 arm");

        // Random mix
        for (int it = 0; it < 300; it++) begin
            int sel = $urandom_range(0, 5);
            if (sel == 0) wr_byte(A_RISE, 8'($urandom));
            else if (sel == 1) wr_byte(A_FALL, 8'($urandom));
            else if (sel == 2) wr_bit(($urandom_range(0, 1) != 0) ? A_RISE : A_FALL,
                                      $urandom_range(0, 7), 1'($urandom));
            else if (sel == 3) begin
                wr_byte(16'hFF00 | 16'($urandom_range(0, 255)), 8'($urandom));
            end
            rd_check(A_RISE, "R2 R3 R4 random rise");
            rd_check(A_FALL, "R2 R3 R4 random fall");
            toggle_check($urandom_range(0, 7), "R6 R7 R8 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule